// File: doc/BRIEF.md
# PWM Scaled Clock Generator

This block makes the time base for a pair of pulse-width channels. A free-running prescale counter produces a one-cycle tick, called clock A, each time it wraps. A programmable scaler divides clock A by the scale value plus one. A toggle stage then halves that rate to give a second tick, S0. Both ticks are single-cycle enables in the system clock domain, so the whole block runs on one clock.

Each channel has a select bit that picks clock A or S0 as its time base. Each channel also has an enable bit. A newly set enable only makes the channel active at the next tick of its selected clock, so a channel always starts on a clean clock boundary. Software reaches five byte-wide registers through a simple write strobe and a combinational read port. A special-mode input lets test software load the prescale counter directly. In special mode a test bit can also stop a scale write from reloading the scaler.

Top module: `pwm_scale_clk`

## Requirements
- R1: While reset is low, every register reads 0, all ticks are low and every channel is inactive.
- R2: The prescale counter counts up by one each cycle and wraps at 2^PRE_W. `clkATick` is high for one cycle when the counter holds its maximum value.
- R3: Address 2 reads the prescale counter at any time. A write to address 2 loads the counter only when `specialMode` is high; otherwise the counter keeps counting as if no write had occurred.
- R4: Address 3 holds the scale value. It can be written and read back at any time.
- R5: With scale value N, `s0Tick` pulses once every 2*(N+1)*2^PRE_W cycles. Each pulse coincides with a `clkATick` pulse.
- R6: A scale value of 0xFF gives 512 clock A periods between S0 ticks.
- R7: A write to address 3 loads the new value into the scaler counter at once. The load is skipped when `specialMode` is high and bit 0 of address 4 (the reload-block bit) is 1.
- R8: Address 1 bit i selects the clock for channel i: 1 gives S0 and 0 gives clock A. `chSelTick[i]` follows the selected tick.
- R9: When address 0 bit i is set, `chActive[i]` stays low until the cycle after the next `chSelTick[i]` pulse, then goes high.
- R10: When address 0 bit i is cleared, `chActive[i]` is low from the next cycle onward. The other channel is not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| specialMode | input | 1 | Test mode: allows prescale writes and reload blocking |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register address (0 enable, 1 select, 2 prescale, 3 scale, 4 test) |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data of the addressed register, zero-extended |
| clkATick | output | 1 | Clock A tick |
| s0Tick | output | 1 | Scaled clock S0 tick |
| chSelTick | output | NUM_CH | Selected tick per channel |
| chActive | output | NUM_CH | Channel active flag per channel |

## Verification
The bench builds the block with PRE_W = 3, so clock A ticks every 8 cycles instead of every 128. This brings the full 0xFF scale case, a 4096-cycle S0 period, within a short run. The scale width stays at its default of 8, so the full range of scale values is exercised. Two channels are kept, so one channel can run on clock A while the other runs on S0, and their enable timing can be compared.

// File: rtl/pwm_scale_pkg.sv
package pwm_scale_pkg;

  typedef enum logic [2:0] {
    RegEnable   = 3'd0,
    RegSelect   = 3'd1,
    RegPrescale = 3'd2,
    RegScale    = 3'd3,
    RegTest     = 3'd4
  } regSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic preLoad;
    logic sclLoad;
  } strobe_t;

endpackage

// File: rtl/pwm_scale_ctrl.sv
module pwm_scale_ctrl
  import pwm_scale_pkg::*;
#(
  parameter int PRE_W  = 7,
  parameter int SCL_W  = 8,
  parameter int NUM_CH = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              specialMode,
  input  logic              wrEn,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [PRE_W-1:0]  preCnt,
  output logic [DATA_W-1:0] rdData,
  output strobe_t           strb,
  output logic [NUM_CH-1:0] chEn,
  output logic [NUM_CH-1:0] chSel,
  output logic [SCL_W-1:0]  scaleVal
);

  logic reloadBlock;
  regSel_e regSel;

  assign regSel = regSel_e'(addr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chEn        <= '0;
      chSel       <= '0;
      scaleVal    <= '0;
      reloadBlock <= 1'b0;
    end else if (wrEn) begin
      case (regSel)
        RegEnable: chEn        <= wrData[NUM_CH-1:0];
        RegSelect: chSel       <= wrData[NUM_CH-1:0];
        RegScale:  scaleVal    <= wrData[SCL_W-1:0];
        RegTest:   reloadBlock <= wrData[0];
        default:   ;
      endcase
    end
  end

  always_comb begin
    strb.preLoad = wrEn && (regSel == RegPrescale) && specialMode;
    strb.sclLoad = wrEn && (regSel == RegScale) && !(specialMode && reloadBlock);
  end

  always_comb begin
    rdData = '0;
    case (regSel)
      RegEnable:   rdData[NUM_CH-1:0] = chEn;
      RegSelect:   rdData[NUM_CH-1:0] = chSel;
      RegPrescale: rdData[PRE_W-1:0]  = preCnt;
      RegScale:    rdData[SCL_W-1:0]  = scaleVal;
      RegTest:     rdData[0]          = reloadBlock;
      default:     rdData = '0;
    endcase
  end

  // R3: a prescale write outside special mode never raises the load strobe
  p_pre_write_gated_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regSel == RegPrescale && !specialMode) |-> !strb.preLoad);

endmodule

// File: rtl/pwm_scale_dp.sv
module pwm_scale_dp
  import pwm_scale_pkg::*;
#(
  parameter int PRE_W  = 7,
  parameter int SCL_W  = 8,
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [PRE_W-1:0]  preLoadVal,
  input  logic [SCL_W-1:0]  sclLoadVal,
  input  logic [SCL_W-1:0]  scaleVal,
  input  logic [NUM_CH-1:0] chEn,
  input  logic [NUM_CH-1:0] chSel,
  output logic [PRE_W-1:0]  preCnt,
  output logic              clkATick,
  output logic              s0Tick,
  output logic [NUM_CH-1:0] chSelTick,
  output logic [NUM_CH-1:0] chActive
);

  localparam logic [PRE_W-1:0] PRE_MAX = {PRE_W{1'b1}};

  logic [SCL_W-1:0] sclCnt;
  logic             halfPhase;
  logic             sclTerm;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              preCnt <= '0;
    else if (strb.preLoad)  preCnt <= preLoadVal;
    else                    preCnt <= preCnt + 1'b1;
  end

  assign clkATick = (preCnt == PRE_MAX);
  assign sclTerm  = clkATick && (sclCnt == '0);
  assign s0Tick   = sclTerm && halfPhase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclCnt    <= '0;
      halfPhase <= 1'b0;
    end else begin
      if (sclTerm) halfPhase <= ~halfPhase;
      if (strb.sclLoad)   sclCnt <= sclLoadVal;
      else if (sclTerm)   sclCnt <= scaleVal;
      else if (clkATick)  sclCnt <= sclCnt - 1'b1;
    end
  end

  // R7: an accepted scale write lands in the scaler counter
  p_scl_reload_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.sclLoad |=> (sclCnt == $past(sclLoadVal)));

  // R5: the scaler steps down by one on each clock A tick
  p_scl_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.sclLoad && clkATick && sclCnt != '0) |=> (sclCnt == $past(sclCnt) - 1'b1));

  // R2: prescaler advances by one unless loaded
  p_pre_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.preLoad |=> (preCnt == $past(preCnt) + 1'b1));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign chSelTick[i] = chSel[i] ? s0Tick : clkATick;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             chActive[i] <= 1'b0;
      else if (!chEn[i])     chActive[i] <= 1'b0;
      else if (chSelTick[i]) chActive[i] <= 1'b1;
    end

    // R9: a channel becomes active only right after its selected tick
    p_act_on_tick_r9: assert property (@(posedge clk) disable iff (!rstN)
      $rose(chActive[i]) |-> $past(chSelTick[i] && chEn[i]));

    // R10: a cleared enable drops the channel on the next cycle
    p_act_drop_r10: assert property (@(posedge clk) disable iff (!rstN)
      !chEn[i] |=> !chActive[i]);
  end

endmodule

// File: rtl/pwm_scale_clk.sv
module pwm_scale_clk
  import pwm_scale_pkg::*;
#(
  parameter int PRE_W  = 7,
  parameter int SCL_W  = 8,
  parameter int NUM_CH = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              specialMode,
  input  logic              wrEn,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              clkATick,
  output logic              s0Tick,
  output logic [NUM_CH-1:0] chSelTick,
  output logic [NUM_CH-1:0] chActive
);

  strobe_t           strb;
  logic [NUM_CH-1:0] chEn;
  logic [NUM_CH-1:0] chSel;
  logic [SCL_W-1:0]  scaleVal;
  logic [PRE_W-1:0]  preCnt;

  pwm_scale_ctrl #(.PRE_W(PRE_W), .SCL_W(SCL_W), .NUM_CH(NUM_CH), .DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .specialMode(specialMode), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .preCnt(preCnt), .rdData(rdData), .strb(strb),
    .chEn(chEn), .chSel(chSel), .scaleVal(scaleVal)
  );

  pwm_scale_dp #(.PRE_W(PRE_W), .SCL_W(SCL_W), .NUM_CH(NUM_CH)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .preLoadVal(wrData[PRE_W-1:0]), .sclLoadVal(wrData[SCL_W-1:0]),
    .scaleVal(scaleVal), .chEn(chEn), .chSel(chSel),
    .preCnt(preCnt), .clkATick(clkATick), .s0Tick(s0Tick),
    .chSelTick(chSelTick), .chActive(chActive)
  );

endmodule

// File: tb/sim_pwm_scale_clk.sv
module sim_pwm_scale_clk;

  localparam int CLK_PERIOD = 10;
  localparam int PRE_W = 3;
  localparam int NCH = 2;
  localparam int NVEC = 5;
  // {scale value, expected S0 period in cycles} for PRE_W = 3
  localparam logic [23:0] VEC [NVEC] = '{
    {8'h00, 16'd16}, {8'h01, 16'd32}, {8'h04, 16'd80},
    {8'h0B, 16'd192}, {8'hFF, 16'd4096}
  };

  logic clk = 0, rstN = 0, specialMode = 0, wrEn = 0;
  logic [2:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic clkATick, s0Tick;
  logic [NCH-1:0] chSelTick, chActive;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_scale_clk #(.PRE_W(PRE_W), .SCL_W(8), .NUM_CH(NCH), .DATA_W(8)) u0 (
    .clk(clk), .rstN(rstN), .specialMode(specialMode), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .clkATick(clkATick), .s0Tick(s0Tick),
    .chSelTick(chSelTick), .chActive(chActive)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // called at a negedge; write lands at the next posedge; returns at the following negedge
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wrData = d; wrEn = 1;
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a; #1; d = rdData;
  endtask

  task automatic measure(output int per, output int misalign);
    int guard;
    misalign = 0; per = 0; guard = 0;
    while (!s0Tick && guard < 10000) begin @(negedge clk); guard++; end
    @(negedge clk); per = 1;
    while (!s0Tick && per < 10000) begin @(negedge clk); per++; end
    if (!clkATick) misalign++;
  endtask

  task automatic countS0(input int n, output int cnt);
    cnt = 0;
    for (int k = 0; k < n; k++) begin @(negedge clk); if (s0Tick) cnt++; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int per, mis, cnt, bad;
    // R1 reset state
    #3;
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d);
      chk(d == 0, "R1 reset readback", d, 0);
    end
    chk({clkATick, s0Tick, chActive} == 0, "R1 reset outputs", {clkATick, s0Tick, chActive}, 0);
    @(negedge clk); @(negedge clk);
    rstN = 1;

    // R3 special-mode load and readback
    specialMode = 1;
    wr(3'd2, 8'd0);
    rd(3'd2, d);
    chk(d == 0, "R3 prescale load in special mode", d, 0);
    specialMode = 0;
    wr(3'd2, 8'd5);
    rd(3'd2, d);
    chk(d == 1, "R3 prescale write ignored", d, 1);
    // R2 free running and tick at max
    bad = 0;
    for (int k = 2; k < 18; k++) begin
      @(negedge clk); #1;
      if (rdData != 8'(k % 8) || clkATick != ((k % 8) == 7)) bad++;
    end
    chk(bad == 0, "R2 prescale count and tick", bad, 0);

    // R4 scale register
    wr(3'd3, 8'hA5);
    rd(3'd3, d);
    chk(d == 8'hA5, "R4 scale readback", d, 8'hA5);

    // R5 R6 table of scale values and periods
    for (int v = 0; v < NVEC; v++) begin
      wr(3'd3, VEC[v][23:16]);
      measure(per, mis);
      chk(per == int'(VEC[v][15:0]), (VEC[v][23:16] == 8'hFF) ? "R6 period at 0xFF" : "R5 S0 period",
          per, int'(VEC[v][15:0]));
      chk(mis == 0, "R5 S0 aligned with clock A", mis, 0);
    end

    // R7 reload and its blocking
    specialMode = 1;
    wr(3'd4, 8'd1);
    wr(3'd3, 8'hFF);
    wr(3'd3, 8'h00);
    countS0(40, cnt);
    chk(cnt == 0, "R7 blocked reload", cnt, 0);
    rd(3'd3, d);
    chk(d == 0, "R7 register still written", d, 0);
    wr(3'd4, 8'd0);
    wr(3'd3, 8'hFF);
    wr(3'd3, 8'h00);
    countS0(40, cnt);
    chk(cnt >= 2, "R7 immediate reload", cnt, 2);
    specialMode = 0;

    // R8 clock selection: ch0 on A, ch1 on S0
    wr(3'd3, 8'h01);
    wr(3'd1, 8'b10);
    bad = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (chSelTick[0] != clkATick || chSelTick[1] != s0Tick) bad++;
    end
    chk(bad == 0, "R8 select routing", bad, 0);

    // R9 enable waits for selected tick
    wr(3'd3, 8'h00);
    wr(3'd0, 8'b01);
    bad = 0;
    while (!chSelTick[0]) begin
      if (chActive[0]) bad++;
      @(negedge clk);
    end
    if (chActive[0]) bad++;
    @(negedge clk);
    chk(bad == 0, "R9 ch0 inactive before tick", bad, 0);
    chk(chActive[0] == 1, "R9 ch0 active after tick", chActive[0], 1);
    wr(3'd0, 8'b11);
    bad = 0;
    while (!chSelTick[1]) begin
      if (chActive[1]) bad++;
      @(negedge clk);
    end
    if (chActive[1]) bad++;
    @(negedge clk);
    chk(bad == 0, "R9 ch1 inactive before S0", bad, 0);
    chk(chActive[1] == 1, "R9 ch1 active after S0", chActive[1], 1);

    // R10 disable
    wr(3'd0, 8'b10);
    @(negedge clk);
    chk(chActive[0] == 0, "R10 ch0 dropped", chActive[0], 0);
    chk(chActive[1] == 1, "R10 ch1 unaffected", chActive[1], 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule